// File: doc/BRIEF.md
# Always-on wake interrupt controller

This block collects the interrupt sources of a small always-on power domain and presents them to a local coprocessor as one level-sensitive interrupt. Up to 64 lines sit in two 32-bit banks, and the lines fall into four kinds, each gated differently. Line 0 is a non-maskable-interrupt channel with a configurable trigger and a set/reset latch. Lines 1 to 15 are direct lines that also go to the host interrupt controller without passing through this block's enables. Lines 16 to 18 are banked peripheral lines that only the coprocessor sees. Lines 19 to 34 each reduce a group of eight host-side shared interrupts, and each member of a group has its own enable.

Software in the coprocessor reaches the block through a simple 32-bit register port. The port has an address, write data, a write strobe and a read path that is combinational from the address. A line reaches the coprocessor when it is pending, enabled, not masked and not held off by its response bit. A vector register returns a programmable base plus four times the index of the lowest line that meets those conditions. The NMI latch, gated by its enable bit, also drives a dedicated output to the host. There is no priority scheme and no fast-interrupt path.

Top module: `aon_wake_intc`

## Requirements
- R1: Registers sit at byte offsets 0x04 (vector base, 32 bits), 0x0C (NMI trigger, bits 1:0), 0x40+4n (enable bank n), 0x50+4n (mask bank n), 0x60+4n (response bank n) and 0xC0+4n (mux-enable word n, bit k of word n enabling shared input 32n+k), and each reads back the value last written.
- R2: NMI trigger code 0 sets the latch on every cycle the pin is low, 1 sets it on a falling edge, 2 sets it on every cycle the pin is high, and 3 sets it on a rising edge. The latch holds until a write to 0x10 with bit 0 set clears it, and a set in the same cycle wins. The latch reads as bit 0 of 0x10, and host_nmi equals the latch ANDed with enable bit 0.
- R3: Mux line g (bit 19+g of the 64-bit line space, 16 lines) is the OR of shared inputs 8g to 8g+7, each counted only while its mux-enable bit is 1.
- R4: host_direct always equals direct_irq, whatever the enable, mask and response registers hold.
- R5: Pending bits 1 to 63 (read at 0x10 and 0x14) show the line inputs sampled on the previous clock: direct_irq[i] at bit i+1, banked_irq[j] at bit 16+j, and the mux lines at bits 19 to 34. Bits 35 to 63 read 0, and writes to bits 1 to 31 of 0x10 are ignored.
- R6: cpu_irq is 1 exactly when some line is pending, enabled, not masked and has its response bit clear.
- R7: A 1 in a mask bit or in a response bit keeps that line off cpu_irq and out of the vector until software clears the bit.
- R8: Reading 0x00 returns the base plus 4 times the index of the lowest line that drives cpu_irq, and returns the base alone when no line does.
- R9: After reset all registers are 0, the NMI latch is clear, and cpu_irq and host_nmi are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| nmi_pin | input | 1 | NMI source pin |
| direct_irq | input | 15 | Direct line inputs (lines 1 to 15) |
| banked_irq | input | 3 | Coprocessor-private banked lines (lines 16 to 18) |
| shared_irq | input | 128 | Host shared interrupts feeding the mux lines |
| host_nmi | output | 1 | Enabled NMI latch toward the host |
| host_direct | output | 15 | Ungated copy of the direct lines toward the host |
| cpu_irq | output | 1 | Global interrupt to the coprocessor |

## Verification
The hardest case to reach from the ports is a clear write to the NMI latch that lands in the same cycle as a trigger hit, where the set must win. The stimulus selects the level-high trigger with the pin held high, issues the clear, and expects the latch to stay set. It then drops the pin and clears again. Edge modes are reached by toggling the pin across single-cycle windows. A cycle-by-cycle behavioural model checks every output and the read path on each clock.

// File: rtl/aon_intc_pkg.sv
package aon_intc_pkg;
   localparam logic [7:0] OFF_VEC   = 8'h00;
   localparam logic [7:0] OFF_BASE  = 8'h04;
   localparam logic [7:0] OFF_NMI   = 8'h0C;
   localparam logic [7:0] OFF_PEND  = 8'h10;
   localparam logic [7:0] OFF_EN    = 8'h40;
   localparam logic [7:0] OFF_MASK  = 8'h50;
   localparam logic [7:0] OFF_RESP  = 8'h60;
   localparam logic [7:0] OFF_MUXEN = 8'hC0;

   typedef enum logic [1:0] {
      TRIG_LVL_LO = 2'd0,
      TRIG_FALL   = 2'd1,
      TRIG_LVL_HI = 2'd2,
      TRIG_RISE   = 2'd3
   } trig_e;
endpackage

// File: rtl/aon_intc_nmi.sv
module aon_intc_nmi
   import aon_intc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin,
   input  trig_e mode,
   input  logic  clr,
   output logic  latch_o
);
   logic prev_q;
   logic hit;

   always_comb begin
      unique case (mode)
         TRIG_LVL_LO: hit = !pin;
         TRIG_FALL:   hit = prev_q && !pin;
         TRIG_LVL_HI: hit = pin;
         TRIG_RISE:   hit = !prev_q && pin;
         default:     hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_o <= 1'b0;
      end else begin
         prev_q <= pin;
         if (hit)      latch_o <= 1'b1;
         else if (clr) latch_o <= 1'b0;
      end
   end
endmodule

// File: rtl/aon_intc_mux.sv
module aon_intc_mux #(
   parameter int MUX_INPUTS = 128,
   parameter int MUX_GROUP  = 8,
   localparam int N_OUT     = MUX_INPUTS / MUX_GROUP
) (
   input  logic [MUX_INPUTS-1:0] src,
   input  logic [MUX_INPUTS-1:0] en,
   output logic [N_OUT-1:0]      line
);
   for (genvar g = 0; g < N_OUT; g++) begin : g_grp
      assign line[g] = |(src[g*MUX_GROUP +: MUX_GROUP] & en[g*MUX_GROUP +: MUX_GROUP]);
   end
endmodule

// File: rtl/aon_intc_vector.sv
module aon_intc_vector #(
   parameter int N_LINES = 64,
   localparam int IW     = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] active,
   input  logic [31:0]        base,
   output logic [31:0]        vec
);
   logic [IW-1:0] idx;

   always_comb begin
      idx = '0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (active[i]) idx = IW'(i);
      end
      vec = base + (32'(idx) << 2);
   end
endmodule

// File: rtl/aon_wake_intc.sv
module aon_wake_intc
   import aon_intc_pkg::*;
#(
   parameter int N_BANKS    = 2,
   parameter int N_DIRECT   = 15,
   parameter int N_BANKED   = 3,
   parameter int MUX_INPUTS = 128,
   parameter int MUX_GROUP  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [7:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  nmi_pin,
   input  logic [N_DIRECT-1:0]   direct_irq,
   input  logic [N_BANKED-1:0]   banked_irq,
   input  logic [MUX_INPUTS-1:0] shared_irq,
   output logic                  host_nmi,
   output logic [N_DIRECT-1:0]   host_direct,
   output logic                  cpu_irq
);
   localparam int N_LINES   = 32 * N_BANKS;
   localparam int MUX_LINES = MUX_INPUTS / MUX_GROUP;
   localparam int MUX_WORDS = MUX_INPUTS / 32;
   localparam int DIRECT_LO = 1;
   localparam int BANKED_LO = DIRECT_LO + N_DIRECT;
   localparam int MUX_LO    = BANKED_LO + N_BANKED;

   if (MUX_INPUTS % MUX_GROUP != 0) begin : g_bad_group
      $error("MUX_INPUTS must be a multiple of MUX_GROUP");
   end
   if (MUX_INPUTS % 32 != 0 || MUX_WORDS > 16) begin : g_bad_words
      $error("MUX_INPUTS must be a multiple of 32 and at most 512");
   end
   if (N_BANKS < 1 || N_BANKS > 4) begin : g_bad_banks
      $error("N_BANKS must lie in 1..4");
   end
   if (MUX_LO + MUX_LINES > N_LINES) begin : g_bad_fit
      $error("line groups do not fit the bank count");
   end

   logic [31:0]          base_q;
   trig_e                trig_q;
   logic [N_LINES-1:0]   en_q, mask_q, resp_q;
   logic [MUX_INPUTS-1:0] muxen_q;
   logic [N_LINES-1:1]   pend_q;
   logic [N_LINES-1:1]   raw;
   logic [MUX_LINES-1:0] mux_line;
   logic                 nmi_lat;
   logic                 nmi_clr;
   logic [N_LINES-1:0]   pending;
   logic [N_LINES-1:0]   active;
   logic [31:0]          vec;

   aon_intc_mux #(.MUX_INPUTS(MUX_INPUTS), .MUX_GROUP(MUX_GROUP)) u_mux (
      .src  (shared_irq),
      .en   (muxen_q),
      .line (mux_line)
   );

   assign nmi_clr = reg_we && (reg_addr == OFF_PEND) && reg_wdata[0];

   aon_intc_nmi u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (nmi_pin),
      .mode    (trig_q),
      .clr     (nmi_clr),
      .latch_o (nmi_lat)
   );

   always_comb begin
      raw = '0;
      raw[DIRECT_LO +: N_DIRECT] = direct_irq;
      raw[BANKED_LO +: N_BANKED] = banked_irq;
      raw[MUX_LO +: MUX_LINES]   = mux_line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         trig_q  <= TRIG_LVL_LO;
         en_q    <= '0;
         mask_q  <= '0;
         resp_q  <= '0;
         muxen_q <= '0;
         pend_q  <= '0;
      end else begin
         pend_q <= raw;
         if (reg_we) begin
            if (reg_addr == OFF_BASE) base_q <= reg_wdata;
            if (reg_addr == OFF_NMI)  trig_q <= trig_e'(reg_wdata[1:0]);
            for (int b = 0; b < N_BANKS; b++) begin
               if (reg_addr == OFF_EN   + 8'(4*b)) en_q[b*32 +: 32]   <= reg_wdata;
               if (reg_addr == OFF_MASK + 8'(4*b)) mask_q[b*32 +: 32] <= reg_wdata;
               if (reg_addr == OFF_RESP + 8'(4*b)) resp_q[b*32 +: 32] <= reg_wdata;
            end
            for (int w = 0; w < MUX_WORDS; w++) begin
               if (reg_addr == OFF_MUXEN + 8'(4*w)) muxen_q[w*32 +: 32] <= reg_wdata;
            end
         end
      end
   end

   assign pending = {pend_q, nmi_lat};
   assign active  = pending & en_q & ~mask_q & ~resp_q;

   aon_intc_vector #(.N_LINES(N_LINES)) u_vec (
      .active (active),
      .base   (base_q),
      .vec    (vec)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFF_VEC)  reg_rdata = vec;
      if (reg_addr == OFF_BASE) reg_rdata = base_q;
      if (reg_addr == OFF_NMI)  reg_rdata = {30'd0, trig_q};
      for (int b = 0; b < N_BANKS; b++) begin
         if (reg_addr == OFF_PEND + 8'(4*b)) reg_rdata = pending[b*32 +: 32];
         if (reg_addr == OFF_EN   + 8'(4*b)) reg_rdata = en_q[b*32 +: 32];
         if (reg_addr == OFF_MASK + 8'(4*b)) reg_rdata = mask_q[b*32 +: 32];
         if (reg_addr == OFF_RESP + 8'(4*b)) reg_rdata = resp_q[b*32 +: 32];
      end
      for (int w = 0; w < MUX_WORDS; w++) begin
         if (reg_addr == OFF_MUXEN + 8'(4*w)) reg_rdata = muxen_q[w*32 +: 32];
      end
   end

   assign cpu_irq     = |active;
   assign host_nmi    = nmi_lat & en_q[0];
   assign host_direct = direct_irq;
endmodule

// File: rtl/aon_intc_chk.sv
module aon_intc_chk #(
   parameter int N_DIRECT = 15,
   parameter int N_LINES  = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic [7:0]          reg_addr,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic [N_DIRECT-1:0] direct_irq,
   input logic                nmi_pin,
   input logic                nmi_lat,
   input logic [1:0]          trig_q,
   input logic [N_LINES-1:0]  en_q,
   input logic [31:0]         base_q,
   input logic                cpu_irq,
   input logic                host_nmi
);
   // R2
   nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_lat && !(reg_we && reg_addr == 8'h10 && reg_wdata[0]) |=> nmi_lat);

   // R2
   nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == 8'h10 && reg_wdata[0] && trig_q == 2'd2 && !nmi_pin |=> !nmi_lat);

   // R5
   pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && reg_addr == 8'h10 |-> reg_rdata[N_DIRECT:1] == $past(direct_irq));

   // R6
   no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q == '0 |-> !cpu_irq && !host_nmi);

   // R8
   idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == 8'h00 && !cpu_irq |-> reg_rdata == base_q);
endmodule

bind aon_wake_intc aon_intc_chk #(.N_DIRECT(N_DIRECT), .N_LINES(N_LINES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .direct_irq (direct_irq),
   .nmi_pin    (nmi_pin),
   .nmi_lat    (nmi_lat),
   .trig_q     (trig_q),
   .en_q       (en_q),
   .base_q     (base_q),
   .cpu_irq    (cpu_irq),
   .host_nmi   (host_nmi)
);

// File: tb/aon_wake_intc_tb_top.sv
`timescale 1ns/100ps
module aon_wake_intc_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [7:0]   reg_addr = 8'h00;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         nmi_pin = 1'b1;
   logic [14:0]  direct_irq = '0;
   logic [2:0]   banked_irq = '0;
   logic [127:0] shared_irq = '0;
   logic         host_nmi;
   logic [14:0]  host_direct;
   logic         cpu_irq;

   int checks = 0;
   int bad = 0;

   always #2 clk = ~clk;

   aon_wake_intc dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_pin(nmi_pin),
      .direct_irq(direct_irq), .banked_irq(banked_irq), .shared_irq(shared_irq),
      .host_nmi(host_nmi), .host_direct(host_direct), .cpu_irq(cpu_irq)
   );

   // behavioural reference model
   logic [31:0]  m_base;
   int           m_trig;
   logic [63:0]  m_en, m_mask, m_resp, m_line;
   logic [127:0] m_muxen;
   logic         m_latch, m_prev;

   function automatic logic [63:0] m_pending();
      logic [63:0] p = m_line;
      p[0] = m_latch;
      return p;
   endfunction

   function automatic logic [63:0] m_active();
      return m_pending() & m_en & ~m_mask & ~m_resp;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [63:0] act = m_active();
      logic [31:0] v = m_base;
      for (int i = 63; i >= 0; i--) if (act[i]) v = m_base + 32'(4 * i);
      case (a)
         8'h00: return v;
         8'h04: return m_base;
         8'h0C: return 32'(m_trig);
         8'h10: return m_pending()[31:0];
         8'h14: return m_pending()[63:32];
         8'h40: return m_en[31:0];
         8'h44: return m_en[63:32];
         8'h50: return m_mask[31:0];
         8'h54: return m_mask[63:32];
         8'h60: return m_resp[31:0];
         8'h64: return m_resp[63:32];
         8'hC0: return m_muxen[31:0];
         8'hC4: return m_muxen[63:32];
         8'hC8: return m_muxen[95:64];
         8'hCC: return m_muxen[127:96];
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_base = 0; m_trig = 0; m_en = 0; m_mask = 0; m_resp = 0;
         m_muxen = 0; m_line = 0; m_latch = 0; m_prev = 0;
      end else begin
         logic hit;
         logic [63:0] nl;
         case (m_trig)
            0: hit = !nmi_pin;
            1: hit = m_prev && !nmi_pin;
            2: hit = nmi_pin;
            default: hit = !m_prev && nmi_pin;
         endcase
         nl = '0;
         for (int i = 0; i < 15; i++) nl[1 + i] = direct_irq[i];
         for (int j = 0; j < 3; j++) nl[16 + j] = banked_irq[j];
         for (int g = 0; g < 16; g++)
            for (int k = 0; k < 8; k++)
               if (shared_irq[g*8+k] && m_muxen[g*8+k]) nl[19 + g] = 1'b1;
         if (hit) m_latch = 1'b1;
         else if (reg_we && reg_addr == 8'h10 && reg_wdata[0]) m_latch = 1'b0;
         m_prev = nmi_pin;
         m_line = nl;
         if (reg_we) begin
            case (reg_addr)
               8'h04: m_base = reg_wdata;
               8'h0C: m_trig = int'(reg_wdata[1:0]);
               8'h40: m_en[31:0] = reg_wdata;
               8'h44: m_en[63:32] = reg_wdata;
               8'h50: m_mask[31:0] = reg_wdata;
               8'h54: m_mask[63:32] = reg_wdata;
               8'h60: m_resp[31:0] = reg_wdata;
               8'h64: m_resp[63:32] = reg_wdata;
               8'hC0: m_muxen[31:0] = reg_wdata;
               8'hC4: m_muxen[63:32] = reg_wdata;
               8'hC8: m_muxen[95:64] = reg_wdata;
               8'hCC: m_muxen[127:96] = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison, away from both edges
   always @(negedge clk) begin
      #1.5;
      if (rst_n) begin
         checks++;
         if (cpu_irq !== |m_active()) begin
            bad++; $display("FAIL R6 cpu_irq actual=%0b expected=%0b", cpu_irq, |m_active());
         end
         checks++;
         if (host_nmi !== (m_latch & m_en[0])) begin
            bad++; $display("FAIL R2 host_nmi actual=%0b expected=%0b", host_nmi, m_latch & m_en[0]);
         end
         checks++;
         if (host_direct !== direct_irq) begin
            bad++; $display("FAIL R4 host_direct actual=%h expected=%h", host_direct, direct_irq);
         end
         checks++;
         if (reg_rdata !== m_read(reg_addr)) begin
            bad++; $display("FAIL R1 rdata@%h actual=%h expected=%h", reg_addr, reg_rdata, m_read(reg_addr));
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b0;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired, run hung");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd(8'h40, d); chk("R9 enable0 after reset", d, 32'h0);
      rd(8'h10, d); chk("R9 pending0 after reset", d, 32'h0);
      chk("R9 cpu_irq after reset", 32'(cpu_irq), 32'h0);
      chk("R9 host_nmi after reset", 32'(host_nmi), 32'h0);
      // R1 base and readback
      wr(8'h04, 32'h0000_1000);
      rd(8'h04, d); chk("R1 base readback", d, 32'h1000);
      rd(8'h00, d); chk("R8 idle vector equals base", d, 32'h1000);
      wr(8'hC4, 32'hA5A5_0000);
      rd(8'hC4, d); chk("R1 mux-enable word1 readback", d, 32'hA5A5_0000);
      wr(8'hC4, 32'h0);
      // direct line 4
      direct_irq = 15'h0008;
      rd(8'h10, d); chk("R5 direct line to pending bit4", d, 32'h10);
      chk("R4 host copy with enable off", 32'(host_direct), 32'h8);
      chk("R6 disabled line quiet", 32'(cpu_irq), 32'h0);
      wr(8'h40, 32'h10);
      chk("R6 enabled line raises cpu_irq", 32'(cpu_irq), 32'h1);
      rd(8'h00, d); chk("R8 vector line 4", d, 32'h1010);
      wr(8'h50, 32'h10);
      chk("R7 mask blocks line", 32'(cpu_irq), 32'h0);
      rd(8'h00, d); chk("R7 masked line out of vector", d, 32'h1000);
      wr(8'h50, 32'h0);
      wr(8'h60, 32'h10);
      chk("R7 response blocks line", 32'(cpu_irq), 32'h0);
      wr(8'h60, 32'h0);
      chk("R7 response cleared restores", 32'(cpu_irq), 32'h1);
      // R5 writes ignored
      wr(8'h10, 32'hFFFF_FFFE);
      rd(8'h10, d); chk("R5 pending write ignored", d, 32'h10);
      // banked line 17
      banked_irq = 3'b010;
      rd(8'h10, d); chk("R5 banked line bit17", d, 32'h0002_0010);
      // R3 mux groups
      shared_irq[9] = 1'b1;
      rd(8'h10, d); chk("R3 disabled mux input ignored", d, 32'h0002_0010);
      wr(8'hC0, 32'h0000_0200);
      rd(8'h10, d); chk("R3 group1 to line 20", d, 32'h0012_0010);
      shared_irq[127] = 1'b1;
      shared_irq[120] = 1'b1;
      wr(8'hCC, 32'h8000_0000);
      rd(8'h14, d); chk("R3 group15 to line 34", d, 32'h4);
      rd(8'h14, d); chk("R5 unused upper lines zero", d & 32'hFFFF_FFF8, 32'h0);
      wr(8'h44, 32'h4);
      wr(8'h40, 32'h0010_0010);
      rd(8'h00, d); chk("R8 lowest of lines 4,20,34", d, 32'h1010);
      wr(8'h50, 32'h0010_0010);
      rd(8'h00, d); chk("R8 line 34 when lower masked", d, 32'h1088);
      wr(8'h50, 32'h0);
      wr(8'h44, 32'h0);
      // R2 NMI rising
      wr(8'h0C, 32'h3);
      rd(8'h0C, d); chk("R1 NMI trigger readback", d, 32'h3);
      wr(8'h40, 32'h1);
      nmi_pin = 1'b0;
      @(negedge clk);
      nmi_pin = 1'b1;
      rd(8'h10, d); chk("R2 rising edge sets latch", d & 32'h1, 32'h1);
      chk("R2 host_nmi on", 32'(host_nmi), 32'h1);
      rd(8'h00, d); chk("R8 NMI is lowest", d, 32'h1000);
      repeat (3) @(negedge clk);
      chk("R2 latch holds on steady pin", 32'(host_nmi), 32'h1);
      wr(8'h10, 32'h1);
      chk("R2 clear write resets latch", 32'(host_nmi), 32'h0);
      // R2 level-high: set wins over clear
      wr(8'h0C, 32'h2);
      wr(8'h10, 32'h1);
      chk("R2 set wins over clear", 32'(host_nmi), 32'h1);
      nmi_pin = 1'b0;
      @(negedge clk);
      wr(8'h10, 32'h1);
      chk("R2 clear after pin drops", 32'(host_nmi), 32'h0);
      // R2 falling
      wr(8'h0C, 32'h1);
      nmi_pin = 1'b1;
      @(negedge clk);
      nmi_pin = 1'b0;
      rd(8'h10, d); chk("R2 falling edge sets latch", d & 32'h1, 32'h1);
      wr(8'h40, 32'h0);
      chk("R2 enable bit0 gates host_nmi", 32'(host_nmi), 32'h0);
      rd(8'h10, d); chk("R2 latch still pending", d & 32'h1, 32'h1);
      chk("R6 nothing enabled", 32'(cpu_irq), 32'h0);
      nmi_pin = 1'b1;
      wr(8'h0C, 32'h3);
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule